// File: doc/BRIEF.md
# Link Low-Power Entry Negotiator

This block is the part of a serial link's link layer that moves a port between the active state and three low-power states. The states are fast-exit idle, slow-exit idle and suspend. Entry always takes a handshake made of link commands. The requesting port sends a go-to-state command. The partner answers with an accept or a reject. After an accept, the requester sends a confirm, and both sides then treat the new state as current. A port in the downstream role starts fast-exit idle entry by itself after its link has been quiet for a programmable number of cycles. A port in the upstream role sends a keep-alive command at a fixed interval while it is active and has nothing queued to transmit.

Received link commands arrive already decoded as a 3-bit code with a valid strobe. Commands to transmit leave the same way, as one-cycle requests. The current power state is a 2-bit output that the physical-layer power control can follow. Waking from a low-power state is reduced to a single wake input.

Top module: `link_pm_negotiator`

## Requirements
- R1: After reset the power state is active (code 0), no transmit request is raised and the handshake-timeout flag is low.
- R2: A downstream port (portIsUp=0) in the active state with a non-zero `u1Timeout` of T raises a go-to-fast-idle command (code 1) on `txCmd` exactly T cycles after `linkActive` drops, if `linkActive` stays low throughout. Any cycle with `linkActive` high restarts the count. A timeout value of 0 never starts hardware-initiated entry.
- R3: While a port waits for an answer to its own request, a received accept (code 4) makes it emit a confirm (code 6) in the next cycle. In that same cycle `linkState` takes the requested state: 1 fast idle, 2 slow idle, 3 suspend.
- R4: While a port waits for an answer to its own request, a received reject (code 5) returns it to the active state and sends no confirm.
- R5: If no answer arrives within RESP_WIN cycles, the port stays active and pulses `hsTimeout` for exactly one cycle. The window is counted after a port sends its request, or after it sends an accept and is waiting for the confirm.
- R6: An active port with no pending header packet answers a received fast- or slow-idle request (code 1 or 2) with an accept. It enters that state when a confirm (code 6) arrives.
- R7: An active port with a pending header packet (`txPending`=1) answers a fast- or slow-idle request with a reject and stays active.
- R8: An upstream port always answers a suspend request (code 3) with an accept, even when a header packet is pending. A downstream port rejects a suspend request.
- R9: An upstream port that is active, not in a handshake and with no pending header packet emits a keep-alive (code 7) every KEEP_CYCLES cycles. It emits none while a header packet is pending or while it is in a low-power state.
- R10: A local request `goReq` of 1, 2 or 3 in the active state sends the matching go-to-state command (same code) in the next cycle.
- R11: In a low-power state, received commands are ignored: no transmit request is raised and the state holds. Asserting `wakeReq` returns the port to active in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-layer clock |
| rstN | input | 1 | Active-low synchronous reset |
| portIsUp | input | 1 | 1 when the port faces upstream, 0 when downstream |
| linkActive | input | 1 | Link traffic seen this cycle |
| txPending | input | 1 | A header packet is queued for transmission |
| u1Timeout | input | TIMER_W | Inactivity cycles before fast-idle entry; 0 disables |
| goReq | input | 2 | Local entry request: 0 none, 1/2/3 target state |
| wakeReq | input | 1 | Return to active from a low-power state |
| rxCmdValid | input | 1 | A decoded link command was received |
| rxCmd | input | 3 | Received command code |
| txCmdValid | output | 1 | One-cycle request to transmit a link command |
| txCmd | output | 3 | Command code to transmit |
| linkState | output | 2 | Current power state: 0 active, 1 fast idle, 2 slow idle, 3 suspend |
| hsTimeout | output | 1 | One-cycle pulse when a handshake window expired |

## Verification
Several properties are checked on every cycle. A confirm is only ever sent right after an accept was received. The timeout flag is a single-cycle pulse and coincides with the active state. A pending packet always turns a fast/slow request into a reject, and an upstream port always accepts suspend. Keep-alives appear only from an active upstream port, and a low-power state never moves or transmits without a wake. The exact cycle counts cannot be shown by those properties: the inactivity delay for each timeout value, its restart by link activity, the response window and the keep-alive period. The bench scenarios measure these counts edge by edge, together with the full accept and reject sequences for every target state.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE    = 2'd0,
    PS_IDLE_FAST = 2'd1,
    PS_IDLE_SLOW = 2'd2,
    PS_SUSPEND   = 2'd3
  } pwrState_t;

  typedef enum logic [2:0] {
    CMD_NONE       = 3'd0,
    CMD_GO_FAST    = 3'd1,
    CMD_GO_SLOW    = 3'd2,
    CMD_GO_SUSPEND = 3'd3,
    CMD_ACCEPT     = 3'd4,
    CMD_REJECT     = 3'd5,
    CMD_CONFIRM    = 3'd6,
    CMD_KEEPALIVE  = 3'd7
  } linkCmd_t;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic runIdle;
    logic runKeep;
    logic clrKeep;
    logic runWin;
  } tmrCtl_t;

  // terminal-count indications back to control
  typedef struct packed {
    logic idleHit;
    logic keepHit;
    logic winHit;
  } tmrHit_t;

endpackage

// File: rtl/lpm_timers.sv
`timescale 1ns/1ps
module lpm_timers
  import lpm_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int KEEP_CYCLES = 2000,
  parameter int RESP_WIN    = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrCtl_t            ctl,
  input  logic [TIMER_W-1:0] u1Timeout,
  output tmrHit_t            hit
);

  localparam int KEEP_W = $clog2(KEEP_CYCLES + 1);
  localparam int WIN_W  = $clog2(RESP_WIN + 1);
  localparam logic [KEEP_W-1:0] KEEP_LAST = KEEP_W'(KEEP_CYCLES - 1);
  localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(RESP_WIN - 1);

  logic [TIMER_W-1:0] idleCnt;
  logic [KEEP_W-1:0]  keepCnt;
  logic [WIN_W-1:0]   winCnt;

  always_comb begin
    hit.idleHit = ctl.runIdle && (idleCnt == u1Timeout - TIMER_W'(1));
    hit.keepHit = ctl.runKeep && !ctl.clrKeep && (keepCnt == KEEP_LAST);
    hit.winHit  = ctl.runWin && (winCnt == WIN_LAST);
  end

  // inactivity counter: any break in the run clears it
  always_ff @(posedge clk) begin
    if (!rstN || !ctl.runIdle || hit.idleHit) idleCnt <= '0;
    else                                      idleCnt <= idleCnt + TIMER_W'(1);
  end

  // keep-alive interval counter, wraps on each emitted keep-alive
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrKeep || !ctl.runKeep || hit.keepHit) keepCnt <= '0;
    else                                                     keepCnt <= keepCnt + KEEP_W'(1);
  end

  // handshake response window
  always_ff @(posedge clk) begin
    if (!rstN || !ctl.runWin || hit.winHit) winCnt <= '0;
    else                                    winCnt <= winCnt + WIN_W'(1);
  end

endmodule

// File: rtl/lpm_fsm.sv
`timescale 1ns/1ps
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               portIsUp,
  input  logic               linkActive,
  input  logic               txPending,
  input  logic [TIMER_W-1:0] u1Timeout,
  input  logic [1:0]         goReq,
  input  logic               wakeReq,
  input  logic               rxCmdValid,
  input  logic [2:0]         rxCmd,
  input  tmrHit_t            hit,
  output tmrCtl_t            ctl,
  output logic               txCmdValid,
  output logic [2:0]         txCmd,
  output logic [1:0]         linkState,
  output logic               hsTimeout
);

  typedef enum logic [1:0] {
    ST_ACTIVE    = 2'd0,
    ST_WAIT_ANS  = 2'd1,
    ST_WAIT_CONF = 2'd2,
    ST_LOW       = 2'd3
  } fsmState_t;

  fsmState_t state, nState;
  pwrState_t target, nTarget, curPwr, nPwr;
  linkCmd_t  rxCode, nCmd, txCode;
  logic      nFire, nTmo, rxGo;

  assign rxCode = linkCmd_t'(rxCmd);
  assign rxGo   = rxCmdValid && (rxCode == CMD_GO_FAST || rxCode == CMD_GO_SLOW ||
                                 rxCode == CMD_GO_SUSPEND);

  always_comb begin
    ctl.runIdle = (state == ST_ACTIVE) && !portIsUp && (u1Timeout != '0) && !linkActive;
    ctl.runKeep = (state == ST_ACTIVE) && portIsUp && !txPending;
    ctl.clrKeep = (state == ST_ACTIVE) && (rxGo || goReq != 2'd0);
    ctl.runWin  = (state == ST_WAIT_ANS) || (state == ST_WAIT_CONF);
  end

  always_comb begin
    nState  = state;
    nTarget = target;
    nPwr    = curPwr;
    nFire   = 1'b0;
    nCmd    = CMD_NONE;
    nTmo    = 1'b0;
    unique case (state)
      ST_ACTIVE: begin
        if (rxGo) begin
          nFire = 1'b1;
          if (rxCode == CMD_GO_SUSPEND ? portIsUp : !txPending) begin
            nCmd    = CMD_ACCEPT;
            nTarget = pwrState_t'(rxCmd[1:0]);
            nState  = ST_WAIT_CONF;
          end else begin
            nCmd = CMD_REJECT;
          end
        end else if (goReq != 2'd0) begin
          nFire   = 1'b1;
          nCmd    = linkCmd_t'({1'b0, goReq});
          nTarget = pwrState_t'(goReq);
          nState  = ST_WAIT_ANS;
        end else if (hit.idleHit) begin
          nFire   = 1'b1;
          nCmd    = CMD_GO_FAST;
          nTarget = PS_IDLE_FAST;
          nState  = ST_WAIT_ANS;
        end else if (hit.keepHit) begin
          nFire = 1'b1;
          nCmd  = CMD_KEEPALIVE;
        end
      end
      ST_WAIT_ANS: begin
        if (rxCmdValid && rxCode == CMD_ACCEPT) begin
          nFire  = 1'b1;
          nCmd   = CMD_CONFIRM;
          nPwr   = target;
          nState = ST_LOW;
        end else if (rxCmdValid && rxCode == CMD_REJECT) begin
          nState = ST_ACTIVE;
        end else if (hit.winHit) begin
          nTmo   = 1'b1;
          nState = ST_ACTIVE;
        end
      end
      ST_WAIT_CONF: begin
        if (rxCmdValid && rxCode == CMD_CONFIRM) begin
          nPwr   = target;
          nState = ST_LOW;
        end else if (hit.winHit) begin
          nTmo   = 1'b1;
          nState = ST_ACTIVE;
        end
      end
      ST_LOW: begin
        if (wakeReq) begin
          nPwr   = PS_ACTIVE;
          nState = ST_ACTIVE;
        end
      end
      default: nState = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_ACTIVE;
      target     <= PS_ACTIVE;
      curPwr     <= PS_ACTIVE;
      txCmdValid <= 1'b0;
      txCode     <= CMD_NONE;
      hsTimeout  <= 1'b0;
    end else begin
      state      <= nState;
      target     <= nTarget;
      curPwr     <= nPwr;
      txCmdValid <= nFire;
      txCode     <= nCmd;
      hsTimeout  <= nTmo;
    end
  end

  assign txCmd     = txCode;
  assign linkState = curPwr;

  AST_CONFIRM_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (txCmdValid && txCmd == CMD_CONFIRM) |-> $past(rxCmdValid && rxCmd == CMD_ACCEPT)); // R3

  AST_TIMEOUT_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    hsTimeout |-> (linkState == PS_ACTIVE)); // R5

  AST_TIMEOUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    hsTimeout |=> !hsTimeout); // R5

  AST_PENDING_REJECTS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && txPending && rxCmdValid &&
     (rxCmd == CMD_GO_FAST || rxCmd == CMD_GO_SLOW))
    |=> (txCmdValid && txCmd == CMD_REJECT && linkState == PS_ACTIVE)); // R7

  AST_SUSPEND_ALWAYS_ACCEPTED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && portIsUp && rxCmdValid && rxCmd == CMD_GO_SUSPEND)
    |=> (txCmdValid && txCmd == CMD_ACCEPT)); // R8

  AST_KEEPALIVE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (txCmdValid && txCmd == CMD_KEEPALIVE) |-> (linkState == PS_ACTIVE && $past(portIsUp))); // R9

  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW && !wakeReq) |=> ($stable(linkState) && !txCmdValid)); // R11

endmodule

// File: rtl/link_pm_negotiator.sv
`timescale 1ns/1ps
module link_pm_negotiator
  import lpm_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int KEEP_CYCLES = 2000,
  parameter int RESP_WIN    = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               portIsUp,
  input  logic               linkActive,
  input  logic               txPending,
  input  logic [TIMER_W-1:0] u1Timeout,
  input  logic [1:0]         goReq,
  input  logic               wakeReq,
  input  logic               rxCmdValid,
  input  logic [2:0]         rxCmd,
  output logic               txCmdValid,
  output logic [2:0]         txCmd,
  output logic [1:0]         linkState,
  output logic               hsTimeout
);

  tmrCtl_t ctl;
  tmrHit_t hit;

  lpm_timers #(
    .TIMER_W    (TIMER_W),
    .KEEP_CYCLES(KEEP_CYCLES),
    .RESP_WIN   (RESP_WIN)
  ) timers (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .u1Timeout(u1Timeout),
    .hit      (hit)
  );

  lpm_fsm #(
    .TIMER_W(TIMER_W)
  ) control (
    .clk       (clk),
    .rstN      (rstN),
    .portIsUp  (portIsUp),
    .linkActive(linkActive),
    .txPending (txPending),
    .u1Timeout (u1Timeout),
    .goReq     (goReq),
    .wakeReq   (wakeReq),
    .rxCmdValid(rxCmdValid),
    .rxCmd     (rxCmd),
    .hit       (hit),
    .ctl       (ctl),
    .txCmdValid(txCmdValid),
    .txCmd     (txCmd),
    .linkState (linkState),
    .hsTimeout (hsTimeout)
  );

endmodule

// File: tb/link_pm_negotiator_test.sv
`timescale 1ns/1ps
module link_pm_negotiator_test;

  localparam int TW   = 8;
  localparam int KEEP = 24;
  localparam int WIN  = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          portIsUp = 1'b0;
  logic          linkActive = 1'b1;
  logic          txPending = 1'b0;
  logic [TW-1:0] u1Timeout = '0;
  logic [1:0]    goReq = 2'd0;
  logic          wakeReq = 1'b0;
  logic          rxCmdValid = 1'b0;
  logic [2:0]    rxCmd = 3'd0;
  logic          txCmdValid;
  logic [2:0]    txCmd;
  logic [1:0]    linkState;
  logic          hsTimeout;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  link_pm_negotiator #(.TIMER_W(TW), .KEEP_CYCLES(KEEP), .RESP_WIN(WIN)) uut (
    .clk(clk), .rstN(rstN), .portIsUp(portIsUp), .linkActive(linkActive),
    .txPending(txPending), .u1Timeout(u1Timeout), .goReq(goReq), .wakeReq(wakeReq),
    .rxCmdValid(rxCmdValid), .rxCmd(rxCmd), .txCmdValid(txCmdValid), .txCmd(txCmd),
    .linkState(linkState), .hsTimeout(hsTimeout));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendRx(input logic [2:0] code);
    rxCmdValid = 1'b1;
    rxCmd      = code;
    tick();
    rxCmdValid = 1'b0;
    rxCmd      = 3'd0;
  endtask

  // edges until a transmit request shows; -1 if none within lim
  task automatic waitTx(input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      tick();
      if (txCmdValid) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic waitTmo(input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      tick();
      if (hsTimeout) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic countTx(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      tick();
      if (txCmdValid) n++;
    end
  endtask

  task automatic wake();
    wakeReq = 1'b1;
    tick();
    wakeReq = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog over all requirements actual=%0d expected=%0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk("R1 reset state", linkState, 0);
    chk("R1 reset tx", txCmdValid, 0);
    chk("R1 reset timeout flag", hsTimeout, 0);

    // R2 delay sweep, each request then rejected (R4)
    for (int t = 1; t <= 12; t++) begin
      linkActive = 1'b1;
      u1Timeout  = TW'(t);
      tick();
      linkActive = 1'b0;
      waitTx(200, n);
      chk("R2 inactivity delay", n, t);
      chk("R2 request code", txCmd, 1);
      sendRx(3'd5);
      chk("R4 no confirm after reject", txCmdValid, 0);
      chk("R4 stays active", linkState, 0);
    end

    // R2 activity restarts the count, then R5 window expiry
    linkActive = 1'b1;
    u1Timeout  = TW'(6);
    tick();
    linkActive = 1'b0;
    countTx(4, n);
    chk("R2 no early request", n, 0);
    linkActive = 1'b1;
    tick();
    linkActive = 1'b0;
    waitTx(50, n);
    chk("R2 restarted delay", n, 6);
    linkActive = 1'b1;
    waitTmo(50, n);
    chk("R5 requester window", n, WIN);
    chk("R5 state after timeout", linkState, 0);
    tick();
    chk("R5 timeout single cycle", hsTimeout, 0);

    // R2 zero disables
    u1Timeout  = '0;
    linkActive = 1'b0;
    countTx(100, n);
    chk("R2 zero timeout disables", n, 0);

    // R3 accept of hardware request, R11 low-power behaviour
    linkActive = 1'b1;
    u1Timeout  = TW'(3);
    tick();
    linkActive = 1'b0;
    waitTx(50, n);
    chk("R2 short delay", n, 3);
    sendRx(3'd4);
    chk("R3 confirm sent", txCmdValid, 1);
    chk("R3 confirm code", txCmd, 6);
    chk("R3 state fast idle", linkState, 1);
    sendRx(3'd2);
    chk("R11 rx ignored tx", txCmdValid, 0);
    chk("R11 rx ignored state", linkState, 1);
    linkActive = 1'b1;
    u1Timeout  = '0;
    wake();
    chk("R11 wake to active", linkState, 0);

    // R10 local requests for every target
    for (int g = 1; g <= 3; g++) begin
      goReq = 2'(g);
      tick();
      goReq = 2'd0;
      chk("R10 local request valid", txCmdValid, 1);
      chk("R10 local request code", txCmd, g);
      sendRx(3'd4);
      chk("R3 confirm code local", txCmd, 6);
      chk("R3 state local", linkState, g);
      wake();
      chk("R11 wake local", linkState, 0);
    end

    // R6 / R7 responder sweep
    for (int lvl = 1; lvl <= 2; lvl++) begin
      for (int p = 0; p <= 1; p++) begin
        txPending = p[0];
        sendRx(3'(lvl));
        chk(p ? "R7 reject code" : "R6 accept code", txCmd, p ? 5 : 4);
        chk("R6 responder answers", txCmdValid, 1);
        if (p == 0) begin
          sendRx(3'd6);
          chk("R6 state after confirm", linkState, lvl);
          chk("R6 nothing sent on confirm", txCmdValid, 0);
          wake();
        end else begin
          chk("R7 state stays active", linkState, 0);
        end
      end
    end
    txPending = 1'b0;

    // R5 responder window
    sendRx(3'd1);
    chk("R6 accept before window", txCmd, 4);
    waitTmo(50, n);
    chk("R5 responder window", n, WIN);
    chk("R5 responder stays active", linkState, 0);

    // R8 suspend handling
    sendRx(3'd3);
    chk("R8 downstream rejects suspend", txCmd, 5);
    txPending = 1'b1;
    portIsUp  = 1'b1;
    sendRx(3'd3);
    chk("R8 upstream accepts suspend", txCmd, 4);
    sendRx(3'd6);
    chk("R8 suspend entered", linkState, 3);
    txPending = 1'b0;
    countTx(3 * KEEP, n);
    chk("R9 no keep-alive in suspend", n, 0);
    wake();

    // R9 keep-alive period
    waitTx(3 * KEEP, n);
    chk("R9 keep-alive code", txCmd, 7);
    for (int k = 0; k < 2; k++) begin
      waitTx(3 * KEEP, n);
      chk("R9 keep-alive interval", n, KEEP);
      chk("R9 keep-alive code repeat", txCmd, 7);
    end
    txPending = 1'b1;
    countTx(3 * KEEP, n);
    chk("R9 none while packet pending", n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule